// File: doc/BRIEF.md
# Strobe-Handshake FIFO with Occupancy Flags

This block is a 64-word by 9-bit first-in first-out buffer. A producer loads words with a write strobe, and a consumer removes them with a read strobe. Each side sees a ready level that drops while a strobe is in progress and comes back when the buffer can take the next action. The word at the head of the queue is held in an output register.

All inputs are sampled on one system clock. Strobe falling edges are found by comparing each strobe with its value on the previous cycle. The block reports two levels: one when the buffer is at least half full, and one when the buffer is near either end.

When the read strobe is held high while a word enters an empty buffer, the output-ready level gives a single-cycle pulse. When the write strobe is held high while a word leaves a full buffer, the input-ready level gives a single-cycle pulse, and the word on the data input is taken during that pulse. This lets two instances be chained in depth.

Top module: `strobe_fifo`

## Requirements
- R1: While reset is high, on the next clock `out_rdy` is 0, `in_rdy` is 1, `data_out` is all zeros, `half_full` is 0 and `near_edge` is 1. The buffer holds no words.
- R2: When `in_rdy` is 1 and `shift_in` is high at a clock edge, `data_in` is stored and `in_rdy` is 0 after that edge. The word is committed at the first edge where `shift_in` is seen low again. After that edge `in_rdy` is 1 unless the buffer now holds 64 words.
- R3: With 64 words stored, `in_rdy` stays 0 and pulses on `shift_in` store nothing.
- R4: When `out_rdy` is 1 and `shift_out` is high at an edge, `out_rdy` is 0 after that edge and `data_out` keeps its value. The word is consumed at the first edge where `shift_out` is seen low again. After that edge the next word appears on `data_out` with `out_rdy` at 1, if such a word exists.
- R5: When the buffer is empty, pulses on `shift_out` have no effect. The last word read stays on `data_out` while `out_rdy` is 0.
- R6: A word committed into an empty buffer while `shift_out` is low appears on `data_out` with `out_rdy` at 1 after the commit edge. `out_rdy` then stays at 1 until `shift_out` rises.
- R7: A word committed into an empty buffer while `shift_out` is high appears on `data_out` with `out_rdy` at 1 for exactly one cycle. The word then stays on `data_out`, and later words are not shown. The next low `shift_out` consumes that word and shows the following one.
- R8: After a read from a full buffer with `shift_in` low, `in_rdy` is 1 after the consume edge and stays 1 until `shift_in` rises.
- R9: After a read from a full buffer with `shift_in` held high, `in_rdy` is 1 for exactly one cycle. The `data_in` value present in that cycle is stored, and it is committed when `shift_in` goes low.
- R10: If `shift_in` is high when reset is released, `data_in` is stored at the first clock edge after release. `in_rdy` then stays 0 until `shift_in` falls.
- R11: `half_full` is 1 exactly when at least 32 words are stored, counting the word on `data_out` until it is consumed.
- R12: `near_edge` is 1 exactly when at least 56 words are stored, or 8 or fewer words are stored.
- R13: Words leave in the order they were committed, with their values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| shift_in | input | 1 | Write strobe |
| data_in | input | 9 | Word to be written |
| shift_out | input | 1 | Read strobe |
| in_rdy | output | 1 | Buffer can accept a word |
| out_rdy | output | 1 | `data_out` holds a valid unread word |
| data_out | output | 9 | Registered head word |
| half_full | output | 1 | At least 32 words stored |
| near_edge | output | 1 | At least 56 words, or at most 8 words, stored |

## Verification
The assertions assume that both strobes and reset are synchronous to the clock and that each strobe is a clean level held for at least one cycle. They also assume that a producer raises `shift_in` only while `in_rdy` is 1 or holds it high through a full buffer. The bench drives every input one time unit after a rising edge, so each level lasts at least a full cycle. It starts a normal write only when its model shows free space, and a normal read only when its model shows a word on the output. The cascade and full-buffer cases are applied as directed sequences that hold a strobe high on purpose.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  localparam int unsigned SF_WIDTH_DEF = 9;
  localparam int unsigned SF_DEPTH_DEF = 64;

  typedef struct packed {
    logic half;
    logic near_edge;
  } sf_flags_t;
endpackage

// File: rtl/strobe_fall_det.sv
module strobe_fall_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] sig,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) prev_q <= sig[g];
    assign fall[g] = prev_q & ~sig[g];
  end
endmodule

// File: rtl/strobe_ram.sv
module strobe_ram #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/strobe_level_flags.sv
module strobe_level_flags
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned AF_LEVEL = 56,
  parameter int unsigned AE_LEVEL = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] occ_nx,
  output sf_flags_t     flags
);
  localparam logic [CW-1:0] HALF_L = CW'(DEPTH / 2);
  localparam logic [CW-1:0] AF_L   = CW'(AF_LEVEL);
  localparam logic [CW-1:0] AE_L   = CW'(AE_LEVEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags.half      <= 1'b0;
      flags.near_edge <= 1'b1;
    end else begin
      flags.half      <= (occ_nx >= HALF_L);
      flags.near_edge <= (occ_nx >= AF_L) || (occ_nx <= AE_L);
    end
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned WIDTH    = SF_WIDTH_DEF,
  parameter int unsigned DEPTH    = SF_DEPTH_DEF,
  parameter int unsigned AF_LEVEL = 56,
  parameter int unsigned AE_LEVEL = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] data_in,
  input  logic             shift_out,
  output logic             in_rdy,
  output logic             out_rdy,
  output logic [WIDTH-1:0] data_out,
  output logic             half_full,
  output logic             near_edge
);
  localparam logic [CW-1:0] FULL_L = CW'(DEPTH);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [1:0]    falls;
  logic          si_fall, so_fall;
  logic          wr_pend, shown;
  logic [AW-1:0] wptr, rptr, rptr_nx;
  logic [CW-1:0] occ, occ_nx;
  logic          capture, commit, consume, present;
  logic          pend_nx, shown_left;
  sf_flags_t     flg;

  strobe_fall_det #(.N(2)) u_edges (
    .clk  (clk),
    .sig  ({shift_out, shift_in}),
    .fall (falls)
  );
  assign si_fall = falls[0];
  assign so_fall = falls[1];

  // write side: level capture while ready, commit on strobe fall
  assign capture = shift_in & in_rdy;
  assign commit  = si_fall & wr_pend;
  assign pend_nx = capture | (wr_pend & ~si_fall);

  // read side: consume on strobe fall, then refill the output register
  assign consume    = so_fall & shown;
  assign shown_left = shown & ~consume;
  assign rptr_nx    = consume ? step(rptr) : rptr;
  assign occ_nx     = occ + CW'(commit) - CW'(consume);
  assign present    = ~shown_left & (occ_nx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      occ     <= '0;
      wr_pend <= 1'b0;
      shown   <= 1'b0;
      in_rdy  <= 1'b1;
      out_rdy <= 1'b0;
    end else begin
      if (commit) wptr <= step(wptr);
      rptr    <= rptr_nx;
      occ     <= occ_nx;
      wr_pend <= pend_nx;
      shown   <= shown_left | present;
      in_rdy  <= ~pend_nx & (occ_nx < FULL_L);
      // a held-high read strobe trims any fresh ready to one cycle
      out_rdy <= present | (out_rdy & shown_left & ~shift_out);
    end
  end

  strobe_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (capture),
    .waddr (wptr),
    .wdata (data_in),
    .re    (present),
    .raddr (rptr_nx),
    .rdata (data_out)
  );

  strobe_level_flags #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .occ_nx (occ_nx),
    .flags  (flg)
  );
  assign half_full = flg.half;
  assign near_edge = flg.near_edge;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int unsigned WIDTH    = 9,
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned AF_LEVEL = 56,
  parameter int unsigned AE_LEVEL = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_in,
  input logic             shift_out,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic [WIDTH-1:0] data_out,
  input logic             half_full,
  input logic             near_edge,
  input logic [CW-1:0]    occ
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d) begin
      assert_reset_state_R1: assert (!out_rdy && in_rdy && data_out == '0 && !half_full && near_edge)
        else $error("reset state wrong");
    end
  end

  assert_capture_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
    in_rdy && shift_in |=> !in_rdy);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    occ == CW'(DEPTH) |-> !in_rdy);

  assert_read_drops_ready_R4: assert property (@(posedge clk) disable iff (rst)
    out_rdy && shift_out |=> !out_rdy);

  assert_word_after_ready_low_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_out) |-> !$past(out_rdy));

  assert_empty_not_ready_R5: assert property (@(posedge clk) disable iff (rst)
    occ == '0 |-> !out_rdy);

  assert_half_level_R11: assert property (@(posedge clk) disable iff (rst)
    half_full == (occ >= CW'(DEPTH / 2)));

  assert_edge_level_R12: assert property (@(posedge clk) disable iff (rst)
    near_edge == ((occ >= CW'(AF_LEVEL)) || (occ <= CW'(AE_LEVEL))));
endmodule

bind strobe_fifo strobe_fifo_chk #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_in  (shift_in),
  .shift_out (shift_out),
  .in_rdy    (in_rdy),
  .out_rdy   (out_rdy),
  .data_out  (data_out),
  .half_full (half_full),
  .near_edge (near_edge),
  .occ       (occ)
);

// File: tb/sim_strobe_fifo.sv
`timescale 1ns/1ps
module sim_strobe_fifo;
  localparam int W = 9;
  localparam int D = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst, shift_in, shift_out;
  logic [W-1:0] data_in;
  logic         in_rdy, out_rdy, half_full, near_edge;
  logic [W-1:0] data_out;

  strobe_fifo u0 (
    .clk(clk), .rst(rst), .shift_in(shift_in), .data_in(data_in),
    .shift_out(shift_out), .in_rdy(in_rdy), .out_rdy(out_rdy),
    .data_out(data_out), .half_full(half_full), .near_edge(near_edge)
  );

  int errs = 0;
  int checks = 0;
  logic [W-1:0] mq[$];
  logic [W-1:0] last_rd;

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_half(input int n);
    return (n >= D / 2) ? 1 : 0;
  endfunction

  function automatic int exp_edge(input int n);
    return (n >= 56 || n <= 8) ? 1 : 0;
  endfunction

  task automatic check_flags();
    chk_eq("R11 half_full level", int'(half_full), exp_half(mq.size()));
    chk_eq("R12 near_edge level", int'(near_edge), exp_edge(mq.size()));
  endtask

  task automatic write_word(input logic [W-1:0] d);
    shift_in = 1'b1;
    data_in  = d;
    tick();
    chk_eq("R2 in_rdy low after capture", int'(in_rdy), 0);
    shift_in = 1'b0;
    tick();
    mq.push_back(d);
    chk_eq("R2 R3 in_rdy after commit", int'(in_rdy), (mq.size() < D) ? 1 : 0);
    check_flags();
  endtask

  task automatic read_word();
    logic [W-1:0] held;
    held = data_out;
    chk_eq("R4 out_rdy before read", int'(out_rdy), 1);
    chk_eq("R13 head word", int'(data_out), int'(mq[0]));
    shift_out = 1'b1;
    tick();
    chk_eq("R4 out_rdy drops on strobe", int'(out_rdy), 0);
    chk_eq("R4 word held while strobe high", int'(data_out), int'(held));
    shift_out = 1'b0;
    tick();
    last_rd = mq.pop_front();
    if (mq.size() > 0) begin
      chk_eq("R4 next word ready", int'(out_rdy), 1);
      chk_eq("R13 next word value", int'(data_out), int'(mq[0]));
    end else begin
      chk_eq("R5 empty not ready", int'(out_rdy), 0);
      chk_eq("R5 last word kept", int'(data_out), int'(last_rd));
    end
    chk_eq("R8 R9 in_rdy after read", int'(in_rdy), 1);
    check_flags();
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    rst = 1'b1; shift_in = 1'b0; shift_out = 1'b0; data_in = '0;
    tick(); tick();
    chk_eq("R1 out_rdy", int'(out_rdy), 0);
    chk_eq("R1 in_rdy", int'(in_rdy), 1);
    chk_eq("R1 data_out", int'(data_out), 0);
    chk_eq("R1 half_full", int'(half_full), 0);
    chk_eq("R1 near_edge", int'(near_edge), 1);
    rst = 1'b0;
    tick();

    // R6: fallthrough with read strobe low
    write_word(9'h1a5);
    chk_eq("R6 ready after fallthrough", int'(out_rdy), 1);
    chk_eq("R6 word shown", int'(data_out), 9'h1a5);
    tick(); tick();
    chk_eq("R6 ready held", int'(out_rdy), 1);
    read_word();

    // R5: read strobe on empty buffer
    shift_out = 1'b1; tick();
    shift_out = 1'b0; tick();
    chk_eq("R5 ignored read ready", int'(out_rdy), 0);
    chk_eq("R5 ignored read word", int'(data_out), 9'h1a5);
    chk_eq("R5 ignored read in_rdy", int'(in_rdy), 1);

    // R7: fallthrough with read strobe held high
    shift_out = 1'b1; tick();
    write_word(9'h0f3);
    chk_eq("R7 pulse high", int'(out_rdy), 1);
    chk_eq("R7 word shown", int'(data_out), 9'h0f3);
    tick();
    chk_eq("R7 pulse one cycle", int'(out_rdy), 0);
    chk_eq("R7 word stays", int'(data_out), 9'h0f3);
    write_word(9'h155);
    chk_eq("R7 later word withheld", int'(data_out), 9'h0f3);
    chk_eq("R7 still not ready", int'(out_rdy), 0);
    shift_out = 1'b0; tick();
    last_rd = mq.pop_front();
    chk_eq("R7 consumed then next ready", int'(out_rdy), 1);
    chk_eq("R7 next word", int'(data_out), 9'h155);
    read_word();

    // fill to full, flag boundaries checked on every step
    for (int i = 0; i < D; i++) write_word(W'(i * 7 + 3));
    chk_eq("R3 full not ready", int'(in_rdy), 0);

    // R3: write strobe on full buffer is ignored
    shift_in = 1'b1; data_in = 9'h1ff; tick(); tick();
    chk_eq("R3 ignored write ready", int'(in_rdy), 0);
    shift_in = 1'b0; tick();
    chk_eq("R3 ignored write ready after fall", int'(in_rdy), 0);
    check_flags();

    // R8: read from full with write strobe low
    read_word();
    tick(); tick();
    chk_eq("R8 ready stays high", int'(in_rdy), 1);
    write_word(9'h0aa);

    // R9: read from full with write strobe held high
    shift_in = 1'b1; data_in = 9'h133; tick();
    chk_eq("R9 full while strobe high", int'(in_rdy), 0);
    read_word();
    tick();
    chk_eq("R9 ready pulse one cycle", int'(in_rdy), 0);
    shift_in = 1'b0; tick();
    mq.push_back(9'h133);
    chk_eq("R9 full again", int'(in_rdy), 0);
    check_flags();

    // R13: drain and verify order, including the bubbled word
    while (mq.size() > 0) read_word();

    // random mix of reads and writes
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      if (mq.size() == 0 || (r % 3 != 0 && mq.size() < D)) write_word(r[W+7:8]);
      else read_word();
      repeat (r[1:0] == 2'd0 ? 1 : 0) tick();
    end

    // R10: reset released with write strobe high
    rst = 1'b1; shift_in = 1'b1; data_in = 9'h0c3;
    tick(); tick();
    mq.delete();
    chk_eq("R1 out_rdy again", int'(out_rdy), 0);
    chk_eq("R1 in_rdy again", int'(in_rdy), 1);
    chk_eq("R1 data_out again", int'(data_out), 0);
    rst = 1'b0; tick();
    chk_eq("R10 captured at release", int'(in_rdy), 0);
    shift_in = 1'b0; tick();
    mq.push_back(9'h0c3);
    chk_eq("R10 word ready", int'(out_rdy), 1);
    chk_eq("R10 word value", int'(data_out), 9'h0c3);
    chk_eq("R10 in_rdy back", int'(in_rdy), 1);

    summary();
    $finish;
  end
endmodule